// File: doc/BRIEF.md
# Escaped Word-Stream Frame Extractor

This block sits behind a switch CPU extraction queue that delivers frames as a stream of 32-bit words. Every frame opens with a fixed-length internal header, followed by payload words. Out-of-band events are signalled in-line with eight reserved code words, 0x80000000 to 0x80000007. A payload word whose value happens to equal a code is sent with an escape word in front of it. The block rebuilds one frame at a time. It captures the header, pulls the source port from it, and passes the payload out as a word stream with byte enables. The last beat of each frame carries the frame length with the 4 checksum bytes removed, and a drop flag marks frames that must be discarded.

The output path holds one payload word back. Whether a word is the last one, and how many of its bytes are valid, is only known from the code word that follows it. A header that names a source port outside the configured range makes the block emit a single discard beat. It then stalls its input and raises a flush request for a fixed number of cycles, so the queue can empty itself. An optional byte-swap setting makes the code recognition work on byte-reversed words, while the data passes through unchanged.

Top module: `xtr_frame_rebuild`

## Requirements
- R1: During and right after reset, out_valid is 0, in_ready is 1 and flush_req is 0.
- R2: The first 9 accepted words of each frame are header words. They are taken raw, even when they equal a code word. While they are collected, no beat is emitted, except for the discard beat of R4.
- R3: Header byte k sits in word k/4, at bits [8*(k%4)+7 : 8*(k%4)]. Bytes 27, 28, 29 and 30 form a 32-bit value V, with byte 27 most significant. The source port is bits 7..1 of V>>5. It is reported on out_src_port of every beat of the frame.
- R4: If the source port is 65 (PORT_COUNT) or higher, the last header word produces one beat with sof=1, eof=1, drop=1, be=0, data=0 and len=0. After that beat, flush_req is 1 and in_ready is 0 for exactly 8 (FLUSH_CYCLES) cycles. The next accepted word is then treated as header word 0.
- R5: Each payload word leaves one cycle after the next payload or code word arrives. A non-final beat has be=4'hF, eof=0, drop=0. The first beat of a frame has sof=1 and every other beat has sof=0.
- R6: A code 0x80000000+n (n=0..3) ends the frame with drop=0. The pending word goes out with eof=1. Its be has the low 4-n bits set (bit 0 is the first byte of the word), or is 0 when no payload word is pending. Its len is the payload byte count minus n minus 4, saturated at 0.
- R7: A 0x80000007 code in the payload emits nothing and changes neither the byte count nor the pending word.
- R8: A 0x80000006 code makes the next word literal payload, whatever its value, and adds 4 bytes.
- R9: A 0x80000004 code sends out the pending word as a normal beat. The next word, whatever its value, becomes the final beat, with be=4'hF, eof=1, drop=1 and len equal to the payload byte count minus 4.
- R10: A 0x80000005 code ends the frame with no further data. The pending word (be=4'hF), or an empty beat (be=0), goes out with eof=1, drop=1 and len equal to the byte count minus 4, saturated at 0.
- R11: With cfg_byte_swap=1, each payload word is byte-reversed before it is compared with the codes. Data beats still carry the word exactly as received.
- R12: A beat with eof=1 and drop=0 only ever follows an end-of-frame code (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte_swap | input | 1 | Compare codes on byte-reversed words |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts a word this cycle |
| flush_req | output | 1 | Queue flush request during a port-range drop |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Output payload word |
| out_be | output | 4 | Valid byte lanes, bit 0 is the first byte |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_drop | output | 1 | Frame must be discarded (valid with eof) |
| out_len | output | LEN_W | Frame length without checksum (valid with eof) |
| out_src_port | output | 7 | Source port from the header |

## Verification
A behavioural model in the bench predicts in_ready, flush_req and every output beat on every cycle. It is driven with these patterns:
- Long frames with idle gaps on the input. These separate the one-word hold-back from a plain pass-through.
- Frames with every end code, including an end code with no payload. These check the byte-enable masks and the length saturation.
- Payloads full of escaped codes and not-ready fillers. These tell literal handling apart from code handling.
- Pruned and aborted frames, with and without a pending word.
- Back-to-back out-of-range headers, one exactly at the limit. These check the stall window and the limit comparison.
- A byte-swapped frame whose raw data looks like a code, and whose swapped data does too. This shows that the comparison and the data path use different byte orders.

// File: rtl/xfr_pkg.sv
`timescale 1ns/1ps
// Shared types for the escaped word-stream frame extractor.
// Assumes 32-bit words and the reserved code block 0x80000000..0x80000007.
package xfr_pkg;
    localparam int PORT_W = 7;
    localparam logic [31:0] CODE_BASE = 32'h8000_0000;

    typedef enum logic [2:0] {
        K_DATA, K_EOF, K_PRUNE, K_ABORT, K_ESC, K_NRDY
    } xfr_kind_e;

    typedef enum logic [2:0] {
        ST_HDR, ST_BODY, ST_ESC, ST_PRUNE, ST_FLUSH
    } xfr_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  be;
        logic        sof;
        logic        eof;
        logic        drop;
    } xfr_beat_t;
endpackage

// File: rtl/xfr_code_decode.sv
`timescale 1ns/1ps
// Classifies one input word as data or as one of the reserved codes.
// Assumes: the optional byte reversal applies to the comparison only.
module xfr_code_decode
    import xfr_pkg::*;
(
    input  logic [31:0] word_i,
    input  logic        swap_i,
    output xfr_kind_e   kind_o,
    output logic [1:0]  pad_o
);
    logic [31:0] swapped;
    logic [31:0] cmp;

    // byte-reversed copy of the word, one lane per generate step
    for (genvar g = 0; g < 4; g++) begin : g_rev
        assign swapped[8*g +: 8] = word_i[8*(3-g) +: 8];
    end

    // pick the byte order used for the code comparison
    always_comb cmp = swap_i ? swapped : word_i;

    // map the compared word onto a code kind and end-code pad count
    always_comb begin
        kind_o = K_DATA;
        pad_o  = cmp[1:0];
        if (cmp[31:3] == CODE_BASE[31:3]) begin
            case (cmp[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: kind_o = K_EOF;
                3'd4:                   kind_o = K_PRUNE;
                3'd5:                   kind_o = K_ABORT;
                3'd6:                   kind_o = K_ESC;
                default:                kind_o = K_NRDY;
            endcase
        end
    end
endmodule

// File: rtl/xfr_hdr_capture.sv
`timescale 1ns/1ps
// Captures the four header bytes that hold the source port field and
// derives the port from them. Assumes those bytes all lie in header words
// before the last one, so the port is ready when the last word arrives.
module xfr_hdr_capture
    import xfr_pkg::*;
#(
    parameter int PORT_BYTE = 27,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [31:0]       word_i,
    output logic [PORT_W-1:0] port_o
);
    logic [31:0] field;
    logic        unused_bits;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        localparam int BI = PORT_BYTE + b;
        localparam int WI = BI / 4;
        localparam int LI = BI % 4;
        logic [7:0] byte_q;
        // hold header byte PORT_BYTE+b when its word passes by
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= 8'h00;
            else if (take_i && idx_i == IDX_W'(WI))
                byte_q <= word_i[8*LI +: 8];
        end
    end

    assign field       = {g_lane[0].byte_q, g_lane[1].byte_q,
                          g_lane[2].byte_q, g_lane[3].byte_q};
    // port is bits PORT_W..1 of the field shifted right by five
    assign port_o      = field[PORT_W+5:6];
    assign unused_bits = ^{field[31:PORT_W+6], field[5:0]};
endmodule

// File: rtl/xfr_beat_reg.sv
`timescale 1ns/1ps
// Output register stage for one beat plus its length and port sideband.
// Assumes the caller raises emit_i for at most one beat per cycle.
module xfr_beat_reg
    import xfr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_i,
    input  xfr_beat_t         beat_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              valid_o,
    output xfr_beat_t         beat_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [PORT_W-1:0] port_o
);
    // register the beat on emit, keep the last one otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            beat_o  <= '0;
            len_o   <= '0;
            port_o  <= '0;
        end else begin
            valid_o <= emit_i;
            if (emit_i) begin
                beat_o <= beat_i;
                len_o  <= len_i;
                port_o <= port_i;
            end
        end
    end
endmodule

// File: rtl/xtr_frame_rebuild.sv
`timescale 1ns/1ps
// Rebuilds frames from an escaped 32-bit extraction word stream.
// Collects HDR_WORDS header words, checks the source port against
// PORT_COUNT, then forwards payload words one word late so the following
// code word can mark the end. Assumes the output side is always ready.
module xtr_frame_rebuild
    import xfr_pkg::*;
#(
    parameter int HDR_WORDS    = 9,
    parameter int PORT_BYTE    = 27,
    parameter int PORT_COUNT   = 65,
    parameter int LEN_W        = 16,
    parameter int FLUSH_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte_swap,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              flush_req,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic [3:0]        out_be,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_drop,
    output logic [LEN_W-1:0]  out_len,
    output logic [PORT_W-1:0] out_src_port
);
    localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam int FL_W  = $clog2(FLUSH_CYCLES + 1);
    localparam logic [IDX_W-1:0] HDR_LAST   = IDX_W'(HDR_WORDS - 1);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);
    localparam logic [LEN_W-1:0] FCS_BYTES  = LEN_W'(4);

    xfr_state_e        state_q, state_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [LEN_W-1:0]  bytes_q, bytes_n;
    logic [31:0]       pend_q, pend_n;
    logic              pend_v_q, pend_v_n;
    logic              first_q, first_n;
    logic [PORT_W-1:0] port_q, port_n;
    logic [FL_W-1:0]   fl_q, fl_n;

    logic              acc;
    logic              take_lit;
    logic              port_ok;
    logic              emit;
    xfr_beat_t         beat;
    xfr_beat_t         beat_q;
    logic [LEN_W-1:0]  len_n;
    xfr_kind_e         kind;
    logic [1:0]        pad;
    logic [PORT_W-1:0] hdr_port;

    // saturating subtraction used for the reported length
    function automatic logic [LEN_W-1:0] sat_sub(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        logic [LEN_W:0] d;
        d = {1'b0, a} - {1'b0, b};
        return d[LEN_W] ? '0 : d[LEN_W-1:0];
    endfunction

    // valid-lane mask of the last word for a given count of unused bytes
    function automatic logic [3:0] lane_mask(input logic [1:0] unused);
        case (unused)
            2'd0:    return 4'hF;
            2'd1:    return 4'h7;
            2'd2:    return 4'h3;
            default: return 4'h1;
        endcase
    endfunction

    xfr_code_decode u_decode (
        .word_i (in_data),
        .swap_i (cfg_byte_swap),
        .kind_o (kind),
        .pad_o  (pad)
    );

    xfr_hdr_capture #(
        .PORT_BYTE (PORT_BYTE),
        .IDX_W     (IDX_W)
    ) u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (acc && state_q == ST_HDR),
        .idx_i  (idx_q),
        .word_i (in_data),
        .port_o (hdr_port)
    );

    // input stalls only while a flush is in progress
    assign in_ready  = (state_q != ST_FLUSH);
    assign flush_req = (state_q == ST_FLUSH);
    assign acc       = in_valid && in_ready;

    // range check of the freshly captured source port
    always_comb port_ok = (int'(hdr_port) < PORT_COUNT);

    // frame sequencing: header, payload, escape, prune tail, flush stall
    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        bytes_n  = bytes_q;
        pend_n   = pend_q;
        pend_v_n = pend_v_q;
        first_n  = first_q;
        port_n   = port_q;
        fl_n     = fl_q;
        emit     = 1'b0;
        beat     = '0;
        len_n    = '0;
        take_lit = acc && ((state_q == ST_ESC) ||
                           (state_q == ST_BODY && kind == K_DATA));

        if (take_lit) begin
            bytes_n  = bytes_q + WORD_BYTES;
            pend_n   = in_data;
            pend_v_n = 1'b1;
            if (pend_v_q) begin
                emit      = 1'b1;
                beat.data = pend_q;
                beat.be   = 4'hF;
                beat.sof  = first_q;
                first_n   = 1'b0;
            end
            if (state_q == ST_ESC)
                state_n = ST_BODY;
        end

        case (state_q)
            ST_HDR: begin
                if (acc) begin
                    if (idx_q == HDR_LAST) begin
                        idx_n  = '0;
                        port_n = hdr_port;
                        if (port_ok) begin
                            state_n  = ST_BODY;
                            first_n  = 1'b1;
                            bytes_n  = '0;
                            pend_v_n = 1'b0;
                        end else begin
                            state_n   = ST_FLUSH;
                            fl_n      = FL_W'(FLUSH_CYCLES - 1);
                            emit      = 1'b1;
                            beat.sof  = 1'b1;
                            beat.eof  = 1'b1;
                            beat.drop = 1'b1;
                        end
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_BODY: begin
                if (acc) begin
                    case (kind)
                        K_ESC: state_n = ST_ESC;
                        K_EOF: begin
                            emit      = 1'b1;
                            beat.data = pend_v_q ? pend_q : '0;
                            beat.be   = pend_v_q ? lane_mask(pad) : 4'h0;
                            beat.sof  = first_q;
                            beat.eof  = 1'b1;
                            len_n     = sat_sub(sat_sub(bytes_q, LEN_W'(pad)), FCS_BYTES);
                            pend_v_n  = 1'b0;
                            state_n   = ST_HDR;
                        end
                        K_ABORT: begin
                            emit      = 1'b1;
                            beat.data = pend_v_q ? pend_q : '0;
                            beat.be   = pend_v_q ? 4'hF : 4'h0;
                            beat.sof  = first_q;
                            beat.eof  = 1'b1;
                            beat.drop = 1'b1;
                            len_n     = sat_sub(bytes_q, FCS_BYTES);
                            pend_v_n  = 1'b0;
                            state_n   = ST_HDR;
                        end
                        K_PRUNE: begin
                            if (pend_v_q) begin
                                emit      = 1'b1;
                                beat.data = pend_q;
                                beat.be   = 4'hF;
                                beat.sof  = first_q;
                                first_n   = 1'b0;
                            end
                            pend_v_n = 1'b0;
                            state_n  = ST_PRUNE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PRUNE: begin
                if (acc) begin
                    emit      = 1'b1;
                    beat.data = in_data;
                    beat.be   = 4'hF;
                    beat.sof  = first_q;
                    beat.eof  = 1'b1;
                    beat.drop = 1'b1;
                    len_n     = sat_sub(bytes_q + WORD_BYTES, FCS_BYTES);
                    bytes_n   = bytes_q + WORD_BYTES;
                    state_n   = ST_HDR;
                end
            end
            ST_FLUSH: begin
                if (fl_q == '0)
                    state_n = ST_HDR;
                else
                    fl_n = fl_q - FL_W'(1);
            end
            default: ;
        endcase
    end

    // state registers of the frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HDR;
            idx_q    <= '0;
            bytes_q  <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            first_q  <= 1'b0;
            port_q   <= '0;
            fl_q     <= '0;
        end else begin
            state_q  <= state_n;
            idx_q    <= idx_n;
            bytes_q  <= bytes_n;
            pend_q   <= pend_n;
            pend_v_q <= pend_v_n;
            first_q  <= first_n;
            port_q   <= port_n;
            fl_q     <= fl_n;
        end
    end

    xfr_beat_reg #(
        .LEN_W (LEN_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit_i  (emit),
        .beat_i  (beat),
        .len_i   (len_n),
        .port_i  (port_n),
        .valid_o (out_valid),
        .beat_o  (beat_q),
        .len_o   (out_len),
        .port_o  (out_src_port)
    );

    assign out_data = beat_q.data;
    assign out_be   = beat_q.be;
    assign out_sof  = beat_q.sof;
    assign out_eof  = beat_q.eof;
    assign out_drop = beat_q.drop;

    AST_HDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && acc && idx_q != HDR_LAST) |=> !out_valid); // R2

    AST_FLUSH_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> (out_valid && out_eof && out_drop && out_be == 4'h0)); // R4

    AST_MID_BEAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof) |-> (out_be == 4'hF && !out_drop)); // R5

    AST_NEXT_FRAME_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> (!out_valid || out_sof)); // R5

    AST_NRDY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && acc && kind == K_NRDY) |=> !out_valid); // R7

    AST_ACCEPT_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof && !out_drop) |->
            $past(state_q == ST_BODY && acc && kind == K_EOF)); // R12
endmodule

// File: tb/test_xtr_frame_rebuild.sv
`timescale 1ns/1ps
module test_xtr_frame_rebuild;
    localparam int PCOUNT = 65;
    localparam int FLUSH  = 8;
    localparam int LEN_W  = 16;
    localparam int LIMIT  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_byte_swap = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = 32'h0;
    logic              in_ready, flush_req, out_valid;
    logic [31:0]       out_data;
    logic [3:0]        out_be;
    logic              out_sof, out_eof, out_drop;
    logic [LEN_W-1:0]  out_len;
    logic [6:0]        out_src_port;

    always #2 clk = ~clk;

    xtr_frame_rebuild i_xtr_frame_rebuild (
        .clk(clk), .rst_n(rst_n), .cfg_byte_swap(cfg_byte_swap),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .flush_req(flush_req), .out_valid(out_valid), .out_data(out_data),
        .out_be(out_be), .out_sof(out_sof), .out_eof(out_eof),
        .out_drop(out_drop), .out_len(out_len), .out_src_port(out_src_port)
    );

    int    n_checks = 0, n_err = 0, cyc = 0;
    bit    timed_out = 0, gap_on = 0;
    string cur_req = "R1";
    logic [31:0] sq[$];

    // reference model state: 0 header, 1 body, 2 escape, 3 prune, 4 flush
    int          m_state = 0, m_idx = 0, m_bytes = 0, m_fl = 0, m_port = 0;
    bit          m_pv = 0, m_first = 0;
    logic [31:0] m_pend = 0;
    logic [31:0] m_hdr [9];
    bit          e_valid = 0, e_sof = 0, e_eof = 0, e_drop = 0;
    logic [31:0] e_data = 0;
    logic [3:0]  e_be = 0;
    int          e_len = 0, e_port = 0;

    function automatic logic [31:0] bswap(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] enc(logic [31:0] c);
        return cfg_byte_swap ? bswap(c) : c;
    endfunction

    function automatic int kind_of(logic [31:0] w);
        logic [31:0] c;
        c = cfg_byte_swap ? bswap(w) : w;
        if (c >= 32'h8000_0000 && c <= 32'h8000_0007) return int'(c[2:0]);
        return -1;
    endfunction

    function automatic int hdr_port();
        logic [31:0] v;
        v = 0;
        for (int i = 0; i < 4; i++) begin
            int k;
            k = 27 + i;
            v = {v[23:0], m_hdr[k/4][8*(k%4) +: 8]};
        end
        v = v >> 5;
        return int'(v[7:1]);
    endfunction

    function automatic int max0(int x);
        return (x < 0) ? 0 : x;
    endfunction

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic emit(logic [31:0] d, logic [3:0] be, bit s, bit e, bit dr, int len, int p);
        e_valid = 1; e_data = d; e_be = be; e_sof = s; e_eof = e; e_drop = dr;
        e_len = len; e_port = p;
    endtask

    task automatic lit(logic [31:0] w);
        m_bytes += 4;
        if (m_pv) begin
            emit(m_pend, 4'hF, m_first, 0, 0, 0, m_port);
            m_first = 0;
        end
        m_pend = w;
        m_pv = 1;
    endtask

    task automatic model_step(bit v, logic [31:0] w);
        bit acc;
        int k;
        e_valid = 0;
        acc = v && (m_state != 4);
        case (m_state)
            0: if (acc) begin
                m_hdr[m_idx] = w;
                if (m_idx == 8) begin
                    m_idx = 0;
                    m_port = hdr_port();
                    if (m_port < PCOUNT) begin
                        m_state = 1; m_first = 1; m_bytes = 0; m_pv = 0;
                    end else begin
                        m_state = 4; m_fl = FLUSH;
                        emit(0, 4'h0, 1, 1, 1, 0, m_port);
                    end
                end else m_idx++;
            end
            1: if (acc) begin
                k = kind_of(w);
                if (k < 0) lit(w);
                else if (k == 6) m_state = 2;
                else if (k <= 3) begin
                    emit(m_pv ? m_pend : 32'h0, m_pv ? 4'((1 << (4 - k)) - 1) : 4'h0,
                         m_first, 1, 0, max0(m_bytes - k - 4), m_port);
                    m_pv = 0; m_state = 0;
                end else if (k == 5) begin
                    emit(m_pv ? m_pend : 32'h0, m_pv ? 4'hF : 4'h0,
                         m_first, 1, 1, max0(m_bytes - 4), m_port);
                    m_pv = 0; m_state = 0;
                end else if (k == 4) begin
                    if (m_pv) begin
                        emit(m_pend, 4'hF, m_first, 0, 0, 0, m_port);
                        m_first = 0;
                    end
                    m_pv = 0; m_state = 3;
                end
            end
            2: if (acc) begin lit(w); m_state = 1; end
            3: if (acc) begin
                m_bytes += 4;
                emit(w, 4'hF, m_first, 1, 1, max0(m_bytes - 4), m_port);
                m_state = 0;
            end
            default: begin
                m_fl--;
                if (m_fl == 0) m_state = 0;
            end
        endcase
    endtask

    task automatic cycle();
        bit v;
        logic [31:0] w;
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT && !timed_out) begin
            timed_out = 1; n_checks++; n_err++;
            $display("FAIL %s watchdog: actual=%0d expected<=%0d", cur_req, cyc, LIMIT);
        end
        chk(in_ready === (m_state != 4), "in_ready", 64'(in_ready), 64'(m_state != 4));
        chk(flush_req === (m_state == 4), "flush_req", 64'(flush_req), 64'(m_state == 4));
        chk(out_valid === e_valid, "out_valid", 64'(out_valid), 64'(e_valid));
        if (e_valid && out_valid) begin
            chk(out_data === e_data, "out_data", 64'(out_data), 64'(e_data));
            chk(out_be === e_be, "out_be", 64'(out_be), 64'(e_be));
            chk(out_sof === e_sof, "out_sof", 64'(out_sof), 64'(e_sof));
            chk(out_eof === e_eof, "out_eof", 64'(out_eof), 64'(e_eof));
            chk(out_drop === e_drop, "out_drop", 64'(out_drop), 64'(e_drop));
            chk(int'(out_src_port) == e_port, "out_src_port", 64'(out_src_port), 64'(e_port));
            if (e_eof) chk(int'(out_len) == e_len, "out_len", 64'(out_len), 64'(e_len));
        end
        v = (sq.size() > 0) && !(gap_on && (cyc % 4 == 3)) && !timed_out;
        w = v ? sq[0] : 32'h0;
        in_valid = v;
        in_data  = w;
        if (v && m_state != 4) sq.delete(0);
        model_step(v, w);
    endtask

    task automatic run();
        while (sq.size() > 0 && !timed_out) cycle();
        repeat (FLUSH + 4) cycle();
    endtask

    task automatic frame_hdr(int port, bit raw_code);
        for (int i = 0; i < 9; i++) begin
            logic [31:0] w;
            w = 32'hA500_0000 | (32'(i) << 16) | (32'(i) << 4);
            if (i == 0 && raw_code) w = 32'h8000_0007;
            if (i == 6) w = 32'h5A6B_7C8D;
            if (i == 7) w = 32'h773F_E0C5 | (32'(port & 3) << 22) | (32'(port >> 2) << 8);
            sq.push_back(w);
        end
    endtask

    function automatic logic [31:0] dw(int k);
        return 32'h1000_0000 + 32'(k) * 32'h0001_0203;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk(out_valid === 1'b0, "reset out_valid", 64'(out_valid), 0);
        chk(in_ready === 1'b1, "reset in_ready", 64'(in_ready), 1);
        chk(flush_req === 1'b0, "reset flush_req", 64'(flush_req), 0);
        rst_n = 1'b1;
        cycle();
        chk(out_valid === 1'b0, "R1 out_valid after release", 64'(out_valid), 0);

        // long frame with idle gaps, two unused bytes at the end
        cur_req = "R3/R5/R6"; gap_on = 1;
        frame_hdr(5, 0);
        for (int i = 0; i < 16; i++) sq.push_back(dw(i));
        sq.push_back(enc(32'h8000_0002));
        run();

        // end with no unused bytes, and an end code with no payload
        cur_req = "R6"; gap_on = 0;
        frame_hdr(12, 0); sq.push_back(dw(40)); sq.push_back(enc(32'h8000_0000));
        frame_hdr(13, 0); sq.push_back(enc(32'h8000_0003));
        run();

        // raw code in header, fillers and escaped literal codes in payload
        cur_req = "R2/R7/R8";
        frame_hdr(3, 1);
        sq.push_back(enc(32'h8000_0007)); sq.push_back(dw(1));
        sq.push_back(enc(32'h8000_0007)); sq.push_back(dw(2));
        sq.push_back(enc(32'h8000_0006)); sq.push_back(32'h8000_0003);
        sq.push_back(enc(32'h8000_0007));
        sq.push_back(enc(32'h8000_0006)); sq.push_back(32'h8000_0007);
        sq.push_back(dw(3)); sq.push_back(enc(32'h8000_0001));
        run();

        // pruned frames at the port limit and with nothing pending
        cur_req = "R3/R9";
        frame_hdr(64, 0);
        sq.push_back(dw(5)); sq.push_back(dw(6));
        sq.push_back(enc(32'h8000_0004)); sq.push_back(32'h8000_0005);
        frame_hdr(1, 0);
        sq.push_back(enc(32'h8000_0004)); sq.push_back(32'h8000_0006);
        run();

        // aborted frames with and without a pending word
        cur_req = "R10/R12";
        frame_hdr(0, 0);
        sq.push_back(dw(7)); sq.push_back(dw(8));
        sq.push_back(enc(32'h8000_0006)); sq.push_back(32'h8000_0002);
        sq.push_back(enc(32'h8000_0005));
        frame_hdr(7, 0); sq.push_back(enc(32'h8000_0005));
        run();

        // out-of-range ports back to back, then a good frame
        cur_req = "R4"; gap_on = 1;
        frame_hdr(65, 0);
        frame_hdr(100, 0);
        frame_hdr(2, 0); sq.push_back(dw(9)); sq.push_back(enc(32'h8000_0000));
        run();

        // byte-swapped code comparison with unchanged data
        cur_req = "R11"; gap_on = 0;
        cfg_byte_swap = 1'b1;
        frame_hdr(9, 0);
        sq.push_back(32'h8000_0000);
        sq.push_back(32'h0700_0080);
        sq.push_back(dw(10));
        sq.push_back(enc(32'h8000_0006)); sq.push_back(32'h0600_0080);
        sq.push_back(enc(32'h8000_0001));
        run();
        cfg_byte_swap = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule